// File: doc/BRIEF.md
# Condition flags and evaluator

This block holds a 32-bit processor status word. Its top four bits are the negative, zero, carry and overflow flags. All other bits are unimplemented: they read as zero and ignore writes. Software-visible state reaches the register in one of two ways. A raw write port loads the writable bits, and bits outside the writable mask keep their old value. A flag-update port takes the result of an add or subtract, its carry out, its overflow and the operand width, and sets the four flags on the next clock edge.

The block also evaluates a 4-bit condition code against the flags currently held in the register. It drives a single pass output. Branch, select and conditional-compare logic use this output. The pass output is combinational from the registered flags, so it reflects a flag update starting in the cycle after that update is clocked in.

Top module: `cond_flags_unit`

## Requirements
- R1: A synchronous reset clears the whole status word to zero.
- R2: A raw write changes only bits 31 to 28; every other bit of `status` always reads zero regardless of the written data.
- R3: On a flag update, N (bit 31) takes result bit 31 when `upd_wide` is 0 and result bit 63 when `upd_wide` is 1.
- R4: On a flag update, Z (bit 30) is set exactly when the result is zero at the active width; with `upd_wide` 0, result bits 63 to 32 are ignored.
- R5: On a flag update, C (bit 29) takes `upd_carry` and V (bit 28) takes `upd_ovf`.
- R6: When a raw write and a flag update occur in the same cycle, bits 31 to 28 come from the flag update.
- R7: With neither a raw write nor a flag update, the status word holds its value.
- R8: Codes 0 to 7 test a single flag: 0 Z set, 1 Z clear, 2 C set, 3 C clear, 4 N set, 5 N clear, 6 V set, 7 V clear.
- R9: Code 8 passes when C is set and Z is clear; code 9 passes in exactly the other cases.
- R10: Code 10 passes when N equals V, code 11 when N differs from V, code 12 when Z is clear and N equals V, and code 13 is the inverse of code 12.
- R11: Codes 14 and 15 always pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Raw write strobe |
| wr_data | input | 32 | Raw write value |
| upd_en | input | 1 | Flag-update strobe |
| upd_result | input | 64 | Arithmetic result |
| upd_carry | input | 1 | Carry out of the operation |
| upd_ovf | input | 1 | Signed overflow of the operation |
| upd_wide | input | 1 | 1 for 64-bit operands, 0 for 32-bit |
| cond | input | 4 | Condition code, 0 to 15 |
| status | output | 32 | Current status word |
| pass | output | 1 | Condition evaluates true |

## Verification
The register is visible on `status`, so a wrong flag bit shows up there one clock after the write or update that caused it. A stuck unimplemented bit shows up in the same way. The condition logic only reads the register. For that reason the bench loads all sixteen flag patterns through the raw write port and sweeps all sixteen codes against each one. A single wrong term in the condition mapping therefore fails in the same cycle the code is applied. The width selection for N and Z is only visible when the upper and lower halves of the result disagree, so the update tests use results of that kind.

// File: rtl/cond_flags_unit.sv
module cond_flags_unit #(
  parameter int SW      = 32,
  parameter int DW      = 64,
  parameter logic [SW-1:0] WR_MASK = {4'hF, {(SW-4){1'b0}}}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_data,
  input  logic          upd_en,
  input  logic [DW-1:0] upd_result,
  input  logic          upd_carry,
  input  logic          upd_ovf,
  input  logic          upd_wide,
  input  logic [3:0]    cond,
  output logic [SW-1:0] status,
  output logic          pass
);
  localparam int HW = DW / 2;

  logic [SW-1:0] stat_q, stat_d;
  logic          fn, fz, fc, fv;
  logic          res_neg, res_zero;

  assign res_neg  = upd_wide ? upd_result[DW-1] : upd_result[HW-1];
  assign res_zero = upd_wide ? (upd_result == '0) : (upd_result[HW-1:0] == '0);

  always_comb begin
    stat_d = stat_q;
    if (wr_en)
      stat_d = (stat_q & ~WR_MASK) | (wr_data & WR_MASK);
    if (upd_en)
      stat_d[SW-1:SW-4] = {res_neg, res_zero, upd_carry, upd_ovf};
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= stat_d;
  end

  assign status = stat_q;
  assign {fn, fz, fc, fv} = stat_q[SW-1:SW-4];

  always_comb begin
    case (cond)
      4'd0:    pass = fz;
      4'd1:    pass = !fz;
      4'd2:    pass = fc;
      4'd3:    pass = !fc;
      4'd4:    pass = fn;
      4'd5:    pass = !fn;
      4'd6:    pass = fv;
      4'd7:    pass = !fv;
      4'd8:    pass = fc && !fz;
      4'd9:    pass = !(fc && !fz);
      4'd10:   pass = (fn == fv);
      4'd11:   pass = (fn != fv);
      4'd12:   pass = !fz && (fn == fv);
      4'd13:   pass = !(!fz && (fn == fv));
      default: pass = 1'b1;
    endcase
  end
endmodule

module cond_flags_unit_chk #(
  parameter int SW = 32,
  parameter int DW = 64,
  parameter logic [SW-1:0] WR_MASK = {4'hF, {(SW-4){1'b0}}}
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [SW-1:0] wr_data,
  input logic          upd_en,
  input logic [DW-1:0] upd_result,
  input logic          upd_carry,
  input logic          upd_ovf,
  input logic          upd_wide,
  input logic [3:0]    cond,
  input logic [SW-1:0] status,
  input logic          pass
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> status == '0);
  // R2
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (status & ~WR_MASK) == '0);
  // R5
  carry_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    upd_en |=> status[SW-3:SW-4] == {$past(upd_carry), $past(upd_ovf)});
  // R4
  narrow_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !upd_wide && upd_result[DW/2-1:0] == '0) |=> status[SW-2]);
  // R2
  raw_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !upd_en) |=> status[SW-1:SW-4] == $past(wr_data[SW-1:SW-4]));
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !upd_en) |=> $stable(status));
  // R11
  always_pass_chk: assert property (@(posedge clk) disable iff (rst)
    cond[3:1] == 3'b111 |-> pass);
endmodule

bind cond_flags_unit cond_flags_unit_chk #(.SW(SW), .DW(DW), .WR_MASK(WR_MASK)) u_chk (.*);

// File: tb/cond_flags_unit_tb.sv
module cond_flags_unit_tb;
  logic        clk = 1'b0;
  logic        rst, wr_en, upd_en, upd_carry, upd_ovf, upd_wide;
  logic [31:0] wr_data;
  logic [63:0] upd_result;
  logic [3:0]  cond;
  logic [31:0] status;
  logic        pass;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cond_flags_unit u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic ref_pass(input logic [3:0] f, input logic [3:0] c);
    logic n, z, cy, v, base;
    {n, z, cy, v} = f;
    case (c[3:1])
      3'd0: base = z;
      3'd1: base = cy;
      3'd2: base = n;
      3'd3: base = v;
      3'd4: base = cy & ~z;
      3'd5: base = ~(n ^ v);
      3'd6: base = ~z & ~(n ^ v);
      default: base = 1'b1;
    endcase
    return (c[3:1] == 3'd7) ? 1'b1 : (base ^ c[0]);
  endfunction

  function automatic string req_of(input logic [3:0] c);
    if (c < 8) return "R8";
    if (c < 10) return "R9";
    if (c < 14) return "R10";
    return "R11";
  endfunction

  task automatic idle();
    wr_en = 0; upd_en = 0; wr_data = '0; upd_result = '0;
    upd_carry = 0; upd_ovf = 0; upd_wide = 0;
  endtask

  task automatic raw_write(input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic flag_update(input logic [63:0] r, input logic c, input logic v, input logic w);
    @(negedge clk); upd_en = 1; upd_result = r; upd_carry = c; upd_ovf = v; upd_wide = w;
    @(negedge clk); upd_en = 0;
  endtask

  task automatic t_reset();
    raw_write(32'hF000_0000);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check("R1 reset", status, 32'h0);
  endtask

  task automatic t_raw_write();
    raw_write(32'hFFFF_FFFF);
    check("R2 all ones", status, 32'hF000_0000);
    raw_write(32'h5A5A_5A5A);
    check("R2 pattern", status, 32'h5000_0000);
    raw_write(32'h0FFF_FFFF);
    check("R2 low only", status, 32'h0);
  endtask

  task automatic t_update();
    flag_update(64'h0000_0000_8000_0000, 0, 0, 0);
    check("R3 narrow N", status, 32'h8000_0000);
    flag_update(64'h0000_0000_8000_0000, 0, 0, 1);
    check("R3 wide N", status, 32'h0);
    flag_update(64'h8000_0000_0000_0000, 0, 0, 0);
    check("R4 narrow zero", status, 32'h4000_0000);
    flag_update(64'h8000_0000_0000_0000, 0, 0, 1);
    check("R4 wide nonzero", status, 32'h8000_0000);
    flag_update(64'h0, 1, 0, 1);
    check("R4 R5 wide zero carry", status, 32'h6000_0000);
    flag_update(64'h1, 0, 1, 0);
    check("R5 overflow", status, 32'h1000_0000);
    flag_update(64'h1, 1, 1, 1);
    check("R5 carry and overflow", status, 32'h3000_0000);
  endtask

  task automatic t_priority();
    @(negedge clk);
    wr_en = 1; wr_data = 32'hFFFF_FFFF;
    upd_en = 1; upd_result = 64'h1; upd_carry = 0; upd_ovf = 0; upd_wide = 1;
    @(negedge clk); idle();
    check("R6 update wins", status, 32'h0);
  endtask

  task automatic t_hold();
    raw_write(32'hA000_0000);
    wr_data = 32'h5000_0000; upd_result = '0;
    repeat (3) @(negedge clk);
    check("R7 hold", status, 32'hA000_0000);
  endtask

  task automatic t_cond_sweep();
    for (int f = 0; f < 16; f++) begin
      raw_write({f[3:0], 28'h0});
      for (int c = 0; c < 16; c++) begin
        cond = c[3:0];
        #1;
        check(req_of(c[3:0]), {31'h0, pass}, {31'h0, ref_pass(f[3:0], c[3:0])});
      end
    end
  endtask

  initial begin
    rst = 1; cond = 4'd0; idle();
    repeat (2) @(negedge clk);
    rst = 0;
    t_reset();
    t_raw_write();
    t_update();
    t_priority();
    t_hold();
    t_cond_sweep();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule